// File: doc/BRIEF.md
# Flash Mailbox Command Sequencer

This block is the host-side engine for a register-mapped flash mailbox. It has a simple register access port: one request at a time, each completed by a done strobe that may carry a timeout or an error flag. A caller hands it a job: a flash read, a flash write, an image authenticate or a power cycle. The engine carries out the mailbox protocol and returns one result code together with the byte count moved.

Flash jobs are cut into chunks of at most sixteen 32-bit words. For each write chunk, the engine pulls words from a source port and loads them into the mailbox data registers. For every chunk it then writes a command word and polls the command register until the device clears the request bit. It reads the status register and decodes the code it finds. For a read chunk it then fetches the data registers and streams each word out with its word index inside the job.

The polling loop runs under a cycle-counted deadline: a long one for flash jobs and a short one for authenticate and power cycle. A chunk that times out is issued again a bounded number of times.

Top module: `mbox_seq`

## Requirements
- R1: A flash job of L bytes (L a multiple of 4) is moved in chunks of min(16, remaining) words. The word address grows by the chunk size after each chunk. On success `bytes_done` equals L and `result` is 0.
- R2: The command word is written to register index CMD_IDX (default 17). Its fields are: bits 31:28 hold the operation code (flash write 0, authenticate 1, flash read 2, power cycle 4); bits 27:24 hold the word count (read: n, or 0 when n is 16; write: n-1; authenticate and power cycle: 0); bits 23:2 hold the word address (0 for authenticate and power cycle); bit 1 is 0; bit 0 is 1.
- R3: For a write chunk, all n data registers at indices DATA_BASE+i (default 1+i) are written with consecutive source words before the command word. For a read chunk, the n data registers are read only after a good status. Each word goes out on `rd_data` with `rd_index` = its word offset inside the job.
- R4: After the command, the engine polls the command register until bit 0 reads 0, then reads status index STAT_IDX (default 18). A poll that returns with a timeout is followed by another poll. A poll that returns an error ends the job at once with result 3.
- R5: Polling stops when the deadline has passed: LONG_DL cycles for flash jobs and SHORT_DL cycles for authenticate and power cycle, both counted from the end of the command write. That counts as a chunk timeout.
- R6: A chunk timeout also occurs when the command write, the status read or a data fetch returns a timeout. The chunk is then issued again from the command write, at most MAX_RETRY (3) times per job. A further timeout ends the job with result 3. A transient timeout followed by success still ends with result 0.
- R7: Bits 3:0 of the status register are decoded as follows: 0 is success; 1 gives result 1 (image invalid); 2 gives result 2 (access denied); any other value gives result 3. A code other than 0 ends the job with `bytes_done` equal to the bytes of the chunks already completed.
- R8: Authenticate and power cycle issue exactly one command and no data access. A timeout on either ends the job with result 3, with no retry.
- R9: A job is accepted only while `job_ready` is 1. A `job_valid` pulse during a running job changes neither its commands nor its result.
- R10: `done` is a one-cycle pulse. A flash job with L below 4 completes at once with result 0, `bytes_done` 0 and no register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| job_valid | input | 1 | Start a job (taken only when job_ready) |
| job_op | input | 2 | 0 flash write, 1 flash read, 2 authenticate, 3 power cycle |
| job_dwaddr | input | DWA_W | Flash word address of the job |
| job_len | input | LEN_W | Job length in bytes |
| job_ready | output | 1 | Engine idle |
| done | output | 1 | Job finished pulse |
| result | output | 2 | 0 ok, 1 image invalid, 2 access denied, 3 I/O error |
| bytes_done | output | LEN_W | Bytes moved by completed chunks |
| src_rd | output | 1 | Source word consumed this cycle |
| src_data | input | 32 | Next write word from the caller |
| rd_valid | output | 1 | Read word valid |
| rd_index | output | LEN_W-2 | Word offset of rd_data inside the job |
| rd_data | output | 32 | Read word |
| reg_req | output | 1 | Register access request (one cycle) |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | IDX_W | Mailbox register index |
| reg_wdata | output | 32 | Write data |
| reg_done | input | 1 | Access completed |
| reg_tmo | input | 1 | Completed access timed out |
| reg_err | input | 1 | Completed access failed otherwise |
| reg_rdata | input | 32 | Read data, valid with reg_done |

## Verification
Random reads and writes of 4 to 160 bytes at random word addresses cover single-chunk jobs, exact multiples of 64 bytes and short tails. The checks compare the command word of every chunk, the ordering of data loads against the command, and the flash contents and read stream against a model. Directed cases inject poll timeouts, command-write timeouts, a poll error, hung commands and each status code. These separate tolerated timeouts from retried timeouts and from hard failures. Measuring the time to failure of a hung flash job against a hung authenticate shows which deadline applies and that retries happen only for flash jobs.

// File: rtl/mbox_pkg.sv
// Shared types and helpers for the flash mailbox sequencer.
package mbox_pkg;

    typedef enum logic [1:0] {
        OP_FWRITE = 2'd0,
        OP_FREAD  = 2'd1,
        OP_AUTH   = 2'd2,
        OP_PCYC   = 2'd3
    } mb_op_e;

    typedef enum logic [1:0] {
        RES_OK        = 2'd0,
        RES_BAD_IMAGE = 2'd1,
        RES_DENIED    = 2'd2,
        RES_IO        = 2'd3
    } mb_res_e;

    localparam int unsigned CHUNK_DW = 16;

    // Map a job operation to the 4-bit command code of the mailbox.
    function automatic logic [3:0] op_code(input mb_op_e op);
        case (op)
            OP_FWRITE: return 4'h0;
            OP_AUTH:   return 4'h1;
            OP_FREAD:  return 4'h2;
            default:   return 4'h4;
        endcase
    endfunction

    // Map the device status nibble to a result code.
    function automatic mb_res_e decode_status(input logic [3:0] code);
        case (code)
            4'd0:    return RES_OK;
            4'd1:    return RES_BAD_IMAGE;
            4'd2:    return RES_DENIED;
            default: return RES_IO;
        endcase
    endfunction

endpackage

// File: rtl/mbox_cmd_fmt.sv
// Composes the 32-bit mailbox command word from operation, chunk size and
// word address. Assumes n_dw is 1..16 for flash operations.
module mbox_cmd_fmt
    import mbox_pkg::*;
#(
    parameter int DWA_W = 22
) (
    input  mb_op_e             op,
    input  logic [4:0]         n_dw,
    input  logic [DWA_W-1:0]   dw_addr,
    output logic [31:0]        word
);
    logic [3:0]  cnt_f;
    logic [21:0] addr_f;

    // Select count and address fields per operation.
    always_comb begin
        case (op)
            OP_FREAD: begin
                cnt_f  = (n_dw >= 5'd16) ? 4'd0 : n_dw[3:0];
                addr_f = 22'(dw_addr);
            end
            OP_FWRITE: begin
                cnt_f  = 4'(n_dw - 5'd1);
                addr_f = 22'(dw_addr);
            end
            default: begin
                cnt_f  = 4'd0;
                addr_f = 22'd0;
            end
        endcase
        word = {op_code(op), cnt_f, addr_f, 1'b0, 1'b1};
    end
endmodule

// File: rtl/mbox_timer.sv
// Deadline and poll-gap counters, both in clock cycles. arm loads the
// deadline (short or long); gap_arm loads the poll interval.
module mbox_timer #(
    parameter int LONG_DL  = 500000,
    parameter int SHORT_DL = 15000,
    parameter int POLL_GAP = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic short_sel,
    input  logic gap_arm,
    output logic expired,
    output logic gap_done
);
    localparam int DL_MAX = (LONG_DL > SHORT_DL) ? LONG_DL : SHORT_DL;
    localparam int TW     = $clog2(DL_MAX + 1);
    localparam int GW     = $clog2(POLL_GAP + 1);

    logic [TW-1:0] dl_q;
    logic [GW-1:0] gap_q;

    // Deadline counter: load on arm, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dl_q <= '0;
        else if (arm)
            dl_q <= short_sel ? TW'(SHORT_DL) : TW'(LONG_DL);
        else if (dl_q != '0)
            dl_q <= dl_q - 1'b1;
    end

    // Poll gap counter: load on gap_arm, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (gap_arm)
            gap_q <= GW'(POLL_GAP);
        else if (gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    assign expired  = (dl_q == '0);
    assign gap_done = (gap_q == '0);

    // R5: once expired, the deadline stays expired until re-armed.
    p_expired_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !arm |=> expired);
endmodule

// File: rtl/mbox_seq.sv
// Flash mailbox command sequencer. Splits flash jobs into chunks of up to
// 16 words, issues command, polls, decodes status, moves data, retries
// timed-out chunks. Assumes the register port accepts one access at a time
// and answers each request with exactly one reg_done.
module mbox_seq
    import mbox_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int DWA_W     = 22,
    parameter int IDX_W     = 8,
    parameter int DATA_BASE = 1,
    parameter int CMD_IDX   = 17,
    parameter int STAT_IDX  = 18,
    parameter int POLL_GAP  = 100,
    parameter int LONG_DL   = 500000,
    parameter int SHORT_DL  = 15000,
    parameter int MAX_RETRY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_valid,
    input  logic [1:0]        job_op,
    input  logic [DWA_W-1:0]  job_dwaddr,
    input  logic [LEN_W-1:0]  job_len,
    output logic              job_ready,
    output logic              done,
    output logic [1:0]        result,
    output logic [LEN_W-1:0]  bytes_done,
    output logic              src_rd,
    input  logic [31:0]       src_data,
    output logic              rd_valid,
    output logic [LEN_W-3:0]  rd_index,
    output logic [31:0]       rd_data,
    output logic              reg_req,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_addr,
    output logic [31:0]       reg_wdata,
    input  logic              reg_done,
    input  logic              reg_tmo,
    input  logic              reg_err,
    input  logic [31:0]       reg_rdata
);
    localparam int RDW_W = LEN_W - 2;
    localparam int RT_W  = $clog2(MAX_RETRY + 2);

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_CMD, S_POLL, S_GAP, S_STAT, S_FETCH
    } st_e;

    st_e               state;
    mb_op_e            op_q;
    logic [DWA_W-1:0]  addr_q;
    logic [RDW_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  moved_q;
    logic [3:0]        idx_q;
    logic [RT_W-1:0]   retry_q;
    logic              pend_q;
    logic              done_q;
    mb_res_e           res_q;
    logic              rd_valid_q;
    logic [RDW_W-1:0]  rd_idx_q;
    logic [31:0]       rd_data_q;

    logic [4:0]  chunk_n;
    logic [31:0] cmd_word;
    logic        acc_st, acc_fin, clean, is_flash, last_idx;
    logic        to_ev, pass_ev, dl_arm, gap_arm, expired, gap_done;
    mb_res_e     stat_res;

    // Chunk size: sixteen words or what is left.
    assign chunk_n  = (rem_q >= RDW_W'(CHUNK_DW)) ? 5'd16 : 5'(rem_q);
    assign is_flash = (op_q == OP_FWRITE) || (op_q == OP_FREAD);
    assign acc_st   = (state == S_LOAD) || (state == S_CMD) || (state == S_POLL)
                   || (state == S_STAT) || (state == S_FETCH);
    assign acc_fin  = pend_q && reg_done;
    assign clean    = acc_fin && !reg_tmo && !reg_err;
    assign last_idx = ({1'b0, idx_q} == chunk_n - 5'd1);
    assign stat_res = decode_status(reg_rdata[3:0]);

    mbox_cmd_fmt #(.DWA_W(DWA_W)) u_fmt (
        .op      (op_q),
        .n_dw    (chunk_n),
        .dw_addr (addr_q),
        .word    (cmd_word)
    );

    assign dl_arm  = (state == S_CMD) && clean;
    assign gap_arm = (state == S_POLL) && acc_fin && !reg_err
                  && (reg_tmo || reg_rdata[0]);

    mbox_timer #(.LONG_DL(LONG_DL), .SHORT_DL(SHORT_DL), .POLL_GAP(POLL_GAP)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (dl_arm),
        .short_sel (!is_flash),
        .gap_arm   (gap_arm),
        .expired   (expired),
        .gap_done  (gap_done)
    );

    // Chunk-level events: retryable timeout and clean chunk completion.
    always_comb begin
        to_ev = (acc_fin && reg_tmo && !reg_err
                 && ((state == S_CMD) || (state == S_STAT) || (state == S_FETCH)))
             || ((state == S_GAP) && expired);
        pass_ev = clean && (((state == S_STAT) && (stat_res == RES_OK) && (op_q != OP_FREAD))
                         || ((state == S_FETCH) && last_idx));
    end

    // Register port drive: one request per access state, then wait.
    always_comb begin
        reg_req   = acc_st && !pend_q;
        reg_we    = (state == S_LOAD) || (state == S_CMD);
        reg_wdata = (state == S_LOAD) ? src_data : cmd_word;
        case (state)
            S_LOAD, S_FETCH: reg_addr = IDX_W'(DATA_BASE) + IDX_W'(idx_q);
            S_STAT:          reg_addr = IDX_W'(STAT_IDX);
            default:         reg_addr = IDX_W'(CMD_IDX);
        endcase
    end

    assign src_rd     = reg_req && (state == S_LOAD);
    assign job_ready  = (state == S_IDLE);
    assign done       = done_q;
    assign result     = res_q;
    assign bytes_done = moved_q;
    assign rd_valid   = rd_valid_q;
    assign rd_index   = rd_idx_q;
    assign rd_data    = rd_data_q;

    // Main sequencer: job intake, per-state access handling, retries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            op_q       <= OP_FWRITE;
            addr_q     <= '0;
            rem_q      <= '0;
            len_q      <= '0;
            moved_q    <= '0;
            idx_q      <= '0;
            retry_q    <= '0;
            pend_q     <= 1'b0;
            done_q     <= 1'b0;
            res_q      <= RES_OK;
            rd_valid_q <= 1'b0;
            rd_idx_q   <= '0;
            rd_data_q  <= '0;
        end else begin
            done_q     <= 1'b0;
            rd_valid_q <= 1'b0;
            if (reg_req)
                pend_q <= 1'b1;
            else if (acc_fin)
                pend_q <= 1'b0;

            case (state)
                S_IDLE: if (job_valid) begin
                    op_q    <= mb_op_e'(job_op);
                    addr_q  <= job_dwaddr;
                    rem_q   <= job_len[LEN_W-1:2];
                    len_q   <= {job_len[LEN_W-1:2], 2'b00};
                    moved_q <= '0;
                    idx_q   <= '0;
                    retry_q <= '0;
                    if ((job_op == 2'(OP_FWRITE) || job_op == 2'(OP_FREAD))
                        && job_len[LEN_W-1:2] == '0) begin
                        done_q <= 1'b1;
                        res_q  <= RES_OK;
                    end else begin
                        state <= (job_op == 2'(OP_FWRITE)) ? S_LOAD : S_CMD;
                    end
                end
                S_LOAD: if (acc_fin) begin
                    if (!clean) begin
                        done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                    end else if (last_idx) begin
                        idx_q <= '0; state <= S_CMD;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                S_CMD: if (acc_fin) begin
                    if (reg_err) begin
                        done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                    end else if (!reg_tmo) begin
                        state <= S_POLL;
                    end
                end
                S_POLL: if (acc_fin) begin
                    if (reg_err) begin
                        done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                    end else if (reg_tmo || reg_rdata[0]) begin
                        state <= S_GAP;
                    end else begin
                        state <= S_STAT;
                    end
                end
                S_GAP: if (!expired && gap_done) state <= S_POLL;
                S_STAT: if (acc_fin) begin
                    if (reg_err) begin
                        done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                    end else if (!reg_tmo && stat_res != RES_OK) begin
                        done_q <= 1'b1; res_q <= stat_res; state <= S_IDLE;
                    end else if (!reg_tmo && op_q == OP_FREAD) begin
                        idx_q <= '0; state <= S_FETCH;
                    end
                end
                S_FETCH: if (acc_fin) begin
                    if (reg_err) begin
                        done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                    end else if (!reg_tmo) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= reg_rdata;
                        rd_idx_q   <= moved_q[LEN_W-1:2] + RDW_W'(idx_q);
                        idx_q      <= idx_q + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase

            // Timed-out chunk: issue again from the command, or give up.
            if (to_ev) begin
                if (is_flash && retry_q < RT_W'(MAX_RETRY)) begin
                    retry_q <= retry_q + 1'b1;
                    idx_q   <= '0;
                    state   <= S_CMD;
                end else begin
                    done_q <= 1'b1; res_q <= RES_IO; state <= S_IDLE;
                end
            end

            // Completed chunk: advance or finish.
            if (pass_ev) begin
                idx_q <= '0;
                if (!is_flash) begin
                    done_q <= 1'b1; res_q <= RES_OK; state <= S_IDLE;
                end else begin
                    moved_q <= moved_q + LEN_W'({chunk_n, 2'b00});
                    addr_q  <= addr_q + DWA_W'(chunk_n);
                    rem_q   <= rem_q - RDW_W'(chunk_n);
                    if (rem_q == RDW_W'(chunk_n)) begin
                        done_q <= 1'b1; res_q <= RES_OK; state <= S_IDLE;
                    end else begin
                        state <= (op_q == OP_FWRITE) ? S_LOAD : S_CMD;
                    end
                end
            end
        end
    end

    // R4: at most one register access outstanding.
    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req |=> !reg_req);
    // R2: every command write carries the request bit.
    p_cmd_req_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_req && reg_we && reg_addr == IDX_W'(CMD_IDX) |-> reg_wdata[0]);
    // R6: retries never exceed the bound.
    p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_q <= RT_W'(MAX_RETRY));
    // R10: done lasts one cycle.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1: a successful flash job reports its whole length.
    p_ok_bytes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'(RES_OK) && is_flash |-> bytes_done == len_q);
endmodule

// File: tb/mbox_seq_test.sv
module mbox_seq_test;
    localparam int BUSY = 5;
    localparam int LDL  = 400;
    localparam int SDL  = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        job_valid = 1'b0;
    logic [1:0]  job_op = 2'd0;
    logic [21:0] job_dwaddr = '0;
    logic [15:0] job_len = '0;
    logic        job_ready, done, src_rd, rd_valid, reg_req, reg_we;
    logic [1:0]  result;
    logic [15:0] bytes_done;
    logic [31:0] src_data, rd_data, reg_wdata;
    logic [13:0] rd_index;
    logic [7:0]  reg_addr;
    logic        reg_done = 1'b0, reg_tmo = 1'b0, reg_err = 1'b0;
    logic [31:0] reg_rdata = '0;

    always #2.5 clk = ~clk;

    mbox_seq #(.POLL_GAP(4), .LONG_DL(LDL), .SHORT_DL(SDL), .MAX_RETRY(3)) uut (
        .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_op(job_op),
        .job_dwaddr(job_dwaddr), .job_len(job_len), .job_ready(job_ready),
        .done(done), .result(result), .bytes_done(bytes_done), .src_rd(src_rd),
        .src_data(src_data), .rd_valid(rd_valid), .rd_index(rd_index),
        .rd_data(rd_data), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_done(reg_done), .reg_tmo(reg_tmo),
        .reg_err(reg_err), .reg_rdata(reg_rdata));

    // Mailbox device model state
    logic [31:0] flash [256];
    logic [31:0] dreg [16];
    logic [31:0] wsrc [64];
    logic [31:0] rbuf [64];
    logic [31:0] cmd_log [8];
    logic [31:0] cmd_reg = '0, stat_reg = '0;
    int exec_cnt = 0, hang_cmds = 0, exec_no = 0, bad_no = -1, bad_code = 0;
    int tmo_rd_cmd = 0, tmo_wr_cmd = 0, err_rd_cmd = 0;
    int cmd_att = 0, cmd_logn = 0, loads_since = 0, order_bad = 0, wptr = 0;
    int cyc = 0, done_cyc = 0, nchk = 0, nerr = 0;
    bit m_resp = 0, m_tmo = 0, m_err = 0, done_seen = 0;
    logic [31:0] m_rdata = '0;
    logic [1:0]  got_res = '0;
    logic [15:0] got_bytes = '0;

    assign src_data = wsrc[wptr[5:0]];

    // Executes the command held in cmd_reg.
    task automatic m_exec();
        int n, a, code;
        code = int'(cmd_reg[31:28]);
        a    = int'(cmd_reg[23:2]);
        if (code == 2) begin
            n = (cmd_reg[27:24] == 0) ? 16 : int'(cmd_reg[27:24]);
            for (int i = 0; i < n; i++) dreg[i] = flash[(a + i) % 256];
        end else if (code == 0) begin
            n = int'(cmd_reg[27:24]) + 1;
            for (int i = 0; i < n; i++) flash[(a + i) % 256] = dreg[i];
        end
        stat_reg = {24'd0, cmd_reg[31:28], (exec_no == bad_no) ? 4'(bad_code) : 4'd0};
        exec_no++;
        cmd_reg[0] = 1'b0;
    endtask

    // Device model: answers each access one cycle later, drives at negedge.
    always @(negedge clk) begin
        cyc++;
        reg_done = 1'b0; reg_tmo = 1'b0; reg_err = 1'b0;
        if (exec_cnt > 0) begin
            exec_cnt--;
            if (exec_cnt == 0) m_exec();
        end
        if (m_resp) begin
            reg_done = 1'b1; reg_tmo = m_tmo; reg_err = m_err; reg_rdata = m_rdata;
            m_resp = 0;
        end else if (reg_req) begin
            m_resp = 1; m_tmo = 0; m_err = 0; m_rdata = '0;
            if (reg_we) begin
                if (reg_addr == 8'd17) begin
                    cmd_att++;
                    if (tmo_wr_cmd > 0) begin
                        tmo_wr_cmd--; m_tmo = 1;
                    end else begin
                        cmd_reg = reg_wdata;
                        if (cmd_logn < 8) cmd_log[cmd_logn] = reg_wdata;
                        cmd_logn++;
                        if (reg_wdata[31:28] == 4'h0 && loads_since != int'(reg_wdata[27:24]) + 1)
                            order_bad++;
                        loads_since = 0;
                        if (hang_cmds > 0) begin hang_cmds--; exec_cnt = 0; end
                        else exec_cnt = BUSY;
                    end
                end else if (reg_addr >= 8'd1 && reg_addr <= 8'd16) begin
                    dreg[reg_addr - 8'd1] = reg_wdata;
                    loads_since++;
                    wptr++;
                end
            end else begin
                if (reg_addr == 8'd17 && err_rd_cmd > 0) begin
                    err_rd_cmd--; m_err = 1;
                end else if (reg_addr == 8'd17 && tmo_rd_cmd > 0) begin
                    tmo_rd_cmd--; m_tmo = 1;
                end else if (reg_addr == 8'd17) m_rdata = cmd_reg;
                else if (reg_addr == 8'd18) m_rdata = stat_reg;
                else if (reg_addr >= 8'd1 && reg_addr <= 8'd16) m_rdata = dreg[reg_addr - 8'd1];
            end
        end
        if (rd_valid) rbuf[rd_index[5:0]] = rd_data;
        if (done) begin
            done_seen = 1; got_res = result; got_bytes = bytes_done; done_cyc = cyc;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cmd(input int code, input int n, input int dwa);
        int fld;
        fld = (code == 2) ? ((n == 16) ? 0 : n) : n - 1;
        return {4'(code), 4'(fld), 22'(dwa), 2'b01};
    endfunction

    int start_cyc = 0;
    task automatic run_job(input int op, input int dwa, input int len);
        @(negedge clk);
        done_seen = 0; cmd_att = 0; cmd_logn = 0; wptr = 0; order_bad = 0;
        exec_no = 0; loads_since = 0;
        job_op = 2'(op); job_dwaddr = 22'(dwa); job_len = 16'(len); job_valid = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        job_valid = 1'b0;
        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(negedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int seed, op, dwa, len, n, k, rem;
        logic [31:0] tmp;
        seed = 32'h5eed1234;
        tmp = $urandom(seed);
        for (int i = 0; i < 256; i++) flash[i] = $urandom();
        for (int i = 0; i < 16; i++) dreg[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset job_ready", job_ready, 1);
        chk("R10 reset done", done, 0);
        chk("R4 reset reg_req", reg_req, 0);

        // Random flash jobs, R1 R2 R3
        for (int it = 0; it < 10; it++) begin
            op  = (it % 2 == 0) ? 1 : 0;
            dwa = int'($urandom_range(0, 127));
            len = 4 * int'($urandom_range(1, 40));
            if (it == 2) len = 128;
            if (it == 3) len = 64;
            for (int i = 0; i < 64; i++) begin wsrc[i] = $urandom(); rbuf[i] = 'x; end
            run_job(op, dwa, len);
            chk("R1 result ok", got_res, 0);
            chk("R1 bytes_done", got_bytes, len);
            n = (len / 4 + 15) / 16;
            chk("R1 chunk count", cmd_logn, n);
            rem = len / 4;
            for (k = 0; k < n && k < 8; k++) begin
                chk("R2 command word", cmd_log[k],
                    exp_cmd(op == 1 ? 2 : 0, rem > 16 ? 16 : rem, dwa + 16 * k));
                rem = rem - 16;
            end
            for (int i = 0; i < len / 4; i++) begin
                if (op == 1) chk("R3 read data", rbuf[i], flash[(dwa + i) % 256]);
                else         chk("R3 written flash", flash[(dwa + i) % 256], wsrc[i]);
            end
            if (op == 0) chk("R3 load before command", order_bad, 0);
        end

        // R4 poll timeouts tolerated
        tmo_rd_cmd = 3;
        run_job(1, 10, 8);
        chk("R4 poll timeouts result", got_res, 0);
        chk("R4 poll timeouts single command", cmd_att, 1);
        tmo_rd_cmd = 0;

        // R4 poll error ends at once
        err_rd_cmd = 1;
        run_job(1, 10, 8);
        chk("R4 poll error result", got_res, 3);
        chk("R4 poll error commands", cmd_att, 1);
        err_rd_cmd = 0;

        // R6 transient command-write timeouts retried
        tmo_wr_cmd = 2;
        run_job(1, 20, 16);
        chk("R6 transient result", got_res, 0);
        chk("R6 transient attempts", cmd_att, 3);
        chk("R6 transient data", rbuf[3], flash[23]);

        // R6 transient hang then success
        hang_cmds = 1;
        run_job(0, 40, 8);
        chk("R6 hang once result", got_res, 0);
        chk("R6 hang once commands", cmd_att, 2);

        // R5 R6 flash hang exhausts retries under long deadline
        hang_cmds = 100;
        run_job(1, 0, 8);
        chk("R6 exhausted result", got_res, 3);
        chk("R6 exhausted commands", cmd_att, 4);
        chk("R5 long deadline elapsed", (done_cyc - start_cyc) > 4 * LDL, 1);

        // R5 R8 authenticate hang: short deadline, no retry
        run_job(2, 0, 0);
        chk("R8 auth hang result", got_res, 3);
        chk("R8 auth hang commands", cmd_att, 1);
        chk("R5 short deadline elapsed", (done_cyc - start_cyc) < LDL, 1);
        hang_cmds = 0;

        // R8 R2 authenticate and power cycle words
        run_job(2, 5, 0);
        chk("R8 auth ok", got_res, 0);
        chk("R2 auth word", cmd_log[0], 32'h1000_0001);
        chk("R8 auth no data", wptr, 0);
        run_job(3, 5, 0);
        chk("R8 power ok", got_res, 0);
        chk("R2 power word", cmd_log[0], 32'h4000_0001);

        // R7 status decode
        bad_no = 0; bad_code = 1;
        run_job(1, 30, 100);
        chk("R7 code1 result", got_res, 1);
        chk("R7 code1 bytes", got_bytes, 0);
        bad_code = 2;
        run_job(0, 30, 12);
        chk("R7 code2 result", got_res, 2);
        bad_code = 7;
        run_job(2, 0, 0);
        chk("R7 code7 result", got_res, 3);
        bad_no = 1; bad_code = 2;
        run_job(1, 30, 100);
        chk("R7 second chunk result", got_res, 2);
        chk("R7 second chunk bytes", got_bytes, 64);
        bad_no = -1;

        // R10 zero length
        run_job(0, 3, 0);
        chk("R10 zero length result", got_res, 0);
        chk("R10 zero length bytes", got_bytes, 0);
        chk("R10 zero length no access", cmd_att, 0);

        // R9 job_valid while busy is ignored
        @(negedge clk);
        done_seen = 0; cmd_att = 0; cmd_logn = 0; exec_no = 0;
        job_op = 2'd1; job_dwaddr = 22'd50; job_len = 16'd96; job_valid = 1'b1;
        @(negedge clk);
        job_valid = 1'b0;
        repeat (10) @(negedge clk);
        job_op = 2'd3; job_valid = 1'b1;
        @(negedge clk);
        job_valid = 1'b0;
        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9 busy result", got_res, 0);
        chk("R9 busy bytes", got_bytes, 96);
        chk("R9 busy commands", cmd_logn, 2);
        chk("R9 busy second code", cmd_log[1][31:28], 2);
        chk("R9 idle after", job_ready, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule